// File: doc/BRIEF.md
# LCD Line Scan Address Generator

This block produces the display-side addresses for a panel of 65 common lines and 132 segments. A free-running scan counter steps through the 65 lines, advancing one line per line tick. For each scan line the block gives two indices. The first is the common output being driven. The second is the display-RAM row that feeds it, offset by a programmable start row. Changing the start row therefore scrolls the picture vertically without rewriting memory.

A new start row is held as pending and is copied into use only when the scan wraps back to line 0. A frame is therefore never split between two offsets. The common order can be reversed, in which case the top line comes out on common 63 and the 65th line stays on common 64. The segment order can be mirrored independently.

A segment index presented at the input is translated combinationally into the RAM column that feeds that segment.

Top module: `lcd_scan_addr_gen`

## Requirements
- R1: While rst_ni is low, line_o, row_o and com_idx_o read 0 (with com_rev_i low) and frame_start_o is 0; the start row in use and the pending start row both reset to 0.
- R2: line_o increments by one on each clock edge where line_tick_i is high, wraps from 64 to 0, and holds on edges without a tick.
- R3: frame_start_o is high for exactly the one cycle that follows a tick edge on which line_o went from 64 to 0, and low otherwise.
- R4: row_o equals (active start + line_o) mod 65, where the active start is a 6-bit value.
- R5: A start_we_i write stores start_line_i as pending only. The active start takes the pending value at the wrap edge, so writes made mid-frame leave row_o's progression unchanged until the wrap. Among several writes, the last one before the wrap wins. A write on the wrap edge itself is used for the new frame.
- R6: With com_rev_i low, com_idx_o equals line_o.
- R7: With com_rev_i high, com_idx_o equals 63 - line_o for line_o in 0..63, and equals 64 for line_o = 64.
- R8: With seg_rev_i low, seg_col_o equals seg_idx_i (valid for seg_idx_i 0..131).
- R9: With seg_rev_i high, seg_col_o equals 131 - seg_idx_i, so segment 0 reads column 0x83.
- R10: com_rev_i, seg_rev_i and seg_idx_i act on com_idx_o and seg_col_o in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_tick_i | input | 1 | Advance scan by one line |
| start_we_i | input | 1 | Load pending start row |
| start_line_i | input | 6 | Start row value |
| com_rev_i | input | 1 | Reverse common output order |
| seg_rev_i | input | 1 | Mirror segment order |
| seg_idx_i | input | 8 | Segment index to translate |
| line_o | output | 7 | Current scan line 0..64 |
| com_idx_o | output | 7 | Common output driven for the line |
| row_o | output | 7 | RAM row for the line |
| seg_col_o | output | 8 | RAM column for seg_idx_i |
| frame_start_o | output | 1 | One-cycle pulse after scan wrap |

## Verification
A wrong scan count is visible on line_o and com_idx_o at the next tick edge. It also breaks the one-step progression of row_o at that edge. An active start that changes at the wrong moment shows up one cycle later as a row_o jump in mid-frame. A missed update shows up in the first line of the next frame as a row_o that does not match the last written value. The mapping paths are purely combinational, so the bench compares every field against its own model on every cycle, and any fault appears within one clock of the stimulus that exposes it.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int unsigned LCD_LINES   = 65;
  localparam int unsigned LCD_SEGS    = 132;
  localparam int unsigned LCD_START_W = 6;
endpackage

// File: rtl/lcd_scan_line_ctr.sv
module lcd_scan_line_ctr #(
  parameter int unsigned NUM_LINES = 65,
  localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [LINE_W-1:0] line_o,
  output logic              wrap_o,
  output logic              frame_start_o
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_LINES - 1);

  assign wrap_o = tick_i && (line_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o        <= '0;
      frame_start_o <= 1'b0;
    end else begin
      frame_start_o <= wrap_o;
      if (wrap_o)      line_o <= '0;
      else if (tick_i) line_o <= line_o + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_scan_row_gen.sv
module lcd_scan_row_gen #(
  parameter int unsigned NUM_LINES = 65,
  parameter int unsigned START_W   = 6,
  localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [START_W-1:0] start_i,
  input  logic               wrap_i,
  input  logic [LINE_W-1:0]  line_i,
  output logic [LINE_W-1:0]  row_o
);
  logic [START_W-1:0] pend_q, act_q;
  logic [LINE_W:0]    sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (we_i)   pend_q <= start_i;
      // same-edge write is used by the new frame
      if (wrap_i) act_q  <= we_i ? start_i : pend_q;
    end
  end

  // single subtract suffices: start < NUM_LINES and line < NUM_LINES
  always_comb begin
    sum = (LINE_W+1)'(act_q) + (LINE_W+1)'(line_i);
    if (sum >= (LINE_W+1)'(NUM_LINES)) sum = sum - (LINE_W+1)'(NUM_LINES);
    row_o = sum[LINE_W-1:0];
  end
endmodule

// File: rtl/lcd_scan_com_map.sv
module lcd_scan_com_map #(
  parameter int unsigned NUM_LINES = 65,
  localparam int unsigned LINE_W = $clog2(NUM_LINES),
  localparam int unsigned REV_TOP = NUM_LINES - 2
) (
  input  logic              rev_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [LINE_W-1:0] com_o
);
  // the extra last line keeps its own common in both orders
  always_comb begin
    if (rev_i && (line_i <= LINE_W'(REV_TOP))) com_o = LINE_W'(REV_TOP) - line_i;
    else                                       com_o = line_i;
  end
endmodule

// File: rtl/lcd_scan_seg_map.sv
module lcd_scan_seg_map #(
  parameter int unsigned NUM_SEGS  = 132,
  parameter bit          MIRROR_EN = 1'b1,
  localparam int unsigned SEG_W = $clog2(NUM_SEGS)
) (
  input  logic             rev_i,
  input  logic [SEG_W-1:0] idx_i,
  output logic [SEG_W-1:0] col_o
);
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(NUM_SEGS - 1);

  if (MIRROR_EN) begin : g_mirror
    assign col_o = rev_i ? (SEG_LAST - idx_i) : idx_i;
  end else begin : g_fixed
    logic unused_rev;
    assign unused_rev = rev_i;
    assign col_o = idx_i;
  end
endmodule

// File: rtl/lcd_scan_addr_gen.sv
module lcd_scan_addr_gen
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_LINES = LCD_LINES,
  parameter int unsigned NUM_SEGS  = LCD_SEGS,
  parameter int unsigned START_W   = LCD_START_W,
  parameter bit          SEG_MIRROR_EN = 1'b1,
  localparam int unsigned LINE_W = $clog2(NUM_LINES),
  localparam int unsigned SEG_W  = $clog2(NUM_SEGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_tick_i,
  input  logic               start_we_i,
  input  logic [START_W-1:0] start_line_i,
  input  logic               com_rev_i,
  input  logic               seg_rev_i,
  input  logic [SEG_W-1:0]   seg_idx_i,
  output logic [LINE_W-1:0]  line_o,
  output logic [LINE_W-1:0]  com_idx_o,
  output logic [LINE_W-1:0]  row_o,
  output logic [SEG_W-1:0]   seg_col_o,
  output logic               frame_start_o
);
  logic wrap;

  lcd_scan_line_ctr #(.NUM_LINES(NUM_LINES)) u_line (
    .clk_i, .rst_ni, .tick_i(line_tick_i),
    .line_o, .wrap_o(wrap), .frame_start_o
  );

  lcd_scan_row_gen #(.NUM_LINES(NUM_LINES), .START_W(START_W)) u_row (
    .clk_i, .rst_ni, .we_i(start_we_i), .start_i(start_line_i),
    .wrap_i(wrap), .line_i(line_o), .row_o
  );

  lcd_scan_com_map #(.NUM_LINES(NUM_LINES)) u_com (
    .rev_i(com_rev_i), .line_i(line_o), .com_o(com_idx_o)
  );

  lcd_scan_seg_map #(.NUM_SEGS(NUM_SEGS), .MIRROR_EN(SEG_MIRROR_EN)) u_seg (
    .rev_i(seg_rev_i), .idx_i(seg_idx_i), .col_o(seg_col_o)
  );
endmodule

// File: rtl/lcd_scan_addr_gen_chk.sv
module lcd_scan_addr_gen_chk #(
  parameter int unsigned NUM_LINES = 65,
  parameter int unsigned NUM_SEGS  = 132,
  parameter int unsigned START_W   = 6,
  localparam int unsigned LINE_W = $clog2(NUM_LINES),
  localparam int unsigned SEG_W  = $clog2(NUM_SEGS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               line_tick_i,
  input logic               start_we_i,
  input logic [START_W-1:0] start_line_i,
  input logic               com_rev_i,
  input logic               seg_rev_i,
  input logic [SEG_W-1:0]   seg_idx_i,
  input logic [LINE_W-1:0]  line_o,
  input logic [LINE_W-1:0]  com_idx_o,
  input logic [LINE_W-1:0]  row_o,
  input logic [SEG_W-1:0]   seg_col_o,
  input logic               frame_start_o
);
  localparam int LAST = NUM_LINES - 1;

  assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_tick_i && int'(line_o) != LAST) |=> int'(line_o) == int'($past(line_o)) + 1);

  assert_line_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i |=> $stable(line_o));

  assert_wrap_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_tick_i && int'(line_o) == LAST) |=> (line_o == '0 && frame_start_o));

  assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  assert_row_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(row_o) < NUM_LINES);

  assert_row_midframe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_tick_i && int'(line_o) != LAST) |=> int'(row_o) == (int'($past(row_o)) + 1) % NUM_LINES);

  assert_row_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i |=> $stable(row_o));

  assert_com_normal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_rev_i |-> com_idx_o == line_o);

  assert_com_rev_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_rev_i && int'(line_o) < LAST) |-> int'(com_idx_o) + int'(line_o) == NUM_LINES - 2);

  assert_seg_mirror_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_rev_i && int'(seg_idx_i) < NUM_SEGS) |-> int'(seg_col_o) + int'(seg_idx_i) == NUM_SEGS - 1);
endmodule

bind lcd_scan_addr_gen lcd_scan_addr_gen_chk #(
  .NUM_LINES(NUM_LINES), .NUM_SEGS(NUM_SEGS), .START_W(START_W)
) u_chk (.*);

// File: tb/tb_lcd_scan_addr_gen.sv
module tb_lcd_scan_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, we = 1'b0, com_rev = 1'b0, seg_rev = 1'b0;
  logic [5:0] start = '0;
  logic [7:0] seg_idx = '0;
  logic [6:0] line, com, row;
  logic [7:0] col;
  logic       fs;

  int total = 0, bad = 0, cyc = 0;
  int m_line = 0, m_act = 0, m_pend = 0, m_fs = 0;

  always #2.5 clk = ~clk;

  lcd_scan_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .line_tick_i(tick), .start_we_i(we),
    .start_line_i(start), .com_rev_i(com_rev), .seg_rev_i(seg_rev),
    .seg_idx_i(seg_idx), .line_o(line), .com_idx_o(com), .row_o(row),
    .seg_col_o(col), .frame_start_o(fs)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_act = 0; m_pend = 0; m_fs = 0;
    end else begin
      m_fs = 0;
      if (tick) begin
        if (m_line == 64) begin
          m_line = 0; m_fs = 1;
          m_act = we ? int'(start) : m_pend;
        end else m_line = m_line + 1;
      end
      if (we) m_pend = int'(start);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_com, e_col;
    chk("R2 line", int'(line), m_line);
    chk("R3 frame_start", int'(fs), m_fs);
    chk("R4/R5 row", int'(row), (m_act + m_line) % 65);
    if (!com_rev) e_com = m_line;
    else e_com = (m_line <= 63) ? 63 - m_line : m_line;
    chk(com_rev ? "R7/R10 com" : "R6 com", int'(com), e_com);
    e_col = seg_rev ? 131 - int'(seg_idx) : int'(seg_idx);
    chk(seg_rev ? "R9/R10 seg" : "R8 seg", int'(col), e_col);
  endtask

  initial begin : watchdog
    #(5 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 line", int'(line), 0);
    chk("R1 row", int'(row), 0);
    chk("R1 com", int'(com), 0);
    chk("R1 frame_start", int'(fs), 0);
    rst_n = 1'b1;

    // phase 0: dense ticks, random writes and flags
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      compare_all();
      tick = 1'b1;
      we = ($urandom_range(0, 9) == 0);
      start = 6'($urandom_range(0, 63));
      com_rev = 1'($urandom_range(0, 1));
      seg_rev = 1'($urandom_range(0, 1));
      seg_idx = 8'($urandom_range(0, 131));
    end
    // phase 1: sparse ticks, frequent writes (last write before wrap wins)
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      compare_all();
      tick = ($urandom_range(0, 2) == 0);
      we = ($urandom_range(0, 3) == 0);
      start = 6'($urandom_range(0, 63));
      com_rev = 1'($urandom_range(0, 1));
      seg_rev = 1'($urandom_range(0, 1));
      seg_idx = 8'($urandom_range(0, 131));
    end
    // phase 2: R5 write on the wrap edge itself, extreme start values
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      compare_all();
      tick = 1'b1;
      we = (m_line == 64);
      start = (i % 2 == 0) ? 6'd63 : 6'($urandom_range(0, 63));
      com_rev = (i % 3 == 0);
      seg_rev = (i % 5 == 0);
      seg_idx = (i % 7 == 0) ? 8'd0 : 8'd131;
    end
    // phase 3: R2 hold with no ticks
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      compare_all();
      tick = 1'b0; we = 1'b1;
      start = 6'($urandom_range(0, 63));
    end
    @(negedge clk);
    compare_all();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cyc++;
endmodule